// File: doc/BRIEF.md
# CEC Receive Error Low-Pulse Generator

This block signals a receive error on an open-drain CEC line by pulling the line low for a fixed 3.6 ms. An external bit receiver sends a one-cycle strobe when a data bit falls outside its timing tolerance. If reception and error pulses are both enabled, the block requests the bus driver to hold the line low for that time. Software can also start the same pulse itself. It does this by turning on the error-pulse enable while reception is already enabled and the receiver is idle.

A wait-mode select chooses when the pulse starts. With wait mode off, the pulse starts at once, whatever the current bus level. With wait mode on, the block waits for the next rising edge of the synchronized bus level. The block also keeps a sticky flag that records any change seen on the synchronized bus line. Software clears this flag with a one-cycle clear input. The pulse length is derived from a clock-frequency parameter as a whole number of clock cycles.

Top module: `cec_err_pulse`

## Requirements
- R1: After reset, `pull_low_o`, `busy_o` and `edge_flag_o` are all 0.
- R2: A pulse holds `pull_low_o` at 1 for exactly TICKS = (CLK_HZ/1000)*PULSE_US/1000 consecutive cycles. In immediate mode, `pull_low_o` is 1 in the first cycle after the clock edge that samples the trigger.
- R3: While `err_pulse_en_i` is 0, `pull_low_o` stays 0, whatever strobes arrive on `bit_err_i`.
- R4: With `rx_en_i`=1, `err_pulse_en_i`=1 and `wait_rise_i`=0, a strobe on `bit_err_i` starts a pulse.
- R5: A 0-to-1 change of `err_pulse_en_i` while `rx_en_i`=1 and `rx_busy_i`=0 starts a pulse. The same change while `rx_busy_i`=1 starts none.
- R6: With `wait_rise_i`=1, a trigger leaves the block pending with `busy_o`=1 and `pull_low_o`=0. The pulse starts on the next rising edge of `bus_i` after a two-flop synchronizer: `pull_low_o` is 1 three cycles after `bus_i` rises.
- R7: Strobes and enable changes that arrive while `busy_o` is 1 are ignored. The running pulse keeps its length of TICKS.
- R8: A pending (waiting) pulse is cancelled if either enable is 0 in any cycle of the wait. A pulse already being driven runs its full TICKS even if the enables drop.
- R9: `edge_flag_o` becomes 1 three cycles after any change of `bus_i` and then holds. A one-cycle `edge_clr_i` clears it one cycle later. If a clear and a detected change land on the same clock edge, the flag is set.
- R10: `busy_o` is 1 from the cycle after the trigger until one cycle after `pull_low_o` returns to 0.
- R11: While `rx_en_i` is 0, strobes on `bit_err_i` start no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | Receive enable |
| err_pulse_en_i | input | 1 | Error low-pulse enable |
| wait_rise_i | input | 1 | 1: wait for bus rising edge before pulsing; 0: pulse at once |
| rx_busy_i | input | 1 | Receiver is in the middle of a frame |
| bit_err_i | input | 1 | One-cycle strobe: data bit outside tolerance |
| bus_i | input | 1 | Sampled bus level (asynchronous) |
| edge_clr_i | input | 1 | One-cycle clear of the edge flag |
| pull_low_o | output | 1 | Registered pull-low request to the open-drain driver |
| busy_o | output | 1 | Pulse pending, driving or in its tail cycle |
| edge_flag_o | output | 1 | Sticky bus-change-detected flag |

## Verification
In immediate mode, `pull_low_o` and `busy_o` are due one cycle after the clock edge that samples a strobe or an enable rise. Bus-driven results take three cycles: `edge_flag_o` and a wait-mode pulse start appear only after the synchronizer and the edge register. The bench drives inputs on the falling clock edge and samples one falling edge per rising edge. It checks each result at the exact falling edge where it is due, and one edge earlier where it must still be absent. Pulse length is checked by counting falling edges while `pull_low_o` is high. It is then followed by the single tail cycle in which `busy_o` is still high, both with and without random strobes during the pulse.

// File: rtl/cec_err_pkg.sv
package cec_err_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRIVE = 2'd2,
    ST_TAIL  = 2'd3
  } pulse_state_e;

  // whole cycles for a pulse of us_len microseconds at clk_hz
  function automatic int unsigned pulse_ticks(int unsigned clk_hz, int unsigned us_len);
    return ((clk_hz / 1000) * us_len) / 1000;
  endfunction
endpackage

// File: rtl/cec_bus_sync.sv
module cec_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_i,
  input  logic clr_i,
  output logic rise_o,
  output logic edge_flag_o
);
  logic [STAGES:0] sh_q;
  logic            flag_q;
  logic            any_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], bus_i};
  end

  assign rise_o   = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign any_edge = sh_q[STAGES-1] ^ sh_q[STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (any_edge) flag_q <= 1'b1;   // set wins over clear
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign edge_flag_o = flag_q;

  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !any_edge |=> !edge_flag_o);  // R9
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_edge |=> edge_flag_o);  // R9
endmodule

// File: rtl/cec_pulse_timer.sv
module cec_pulse_timer #(
  parameter int unsigned TICKS = 180000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= CW'(TICKS - 1);
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_TIMER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !load_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);  // R2
  AST_TIMER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == CW'(TICKS - 1));  // R2
endmodule

// File: rtl/cec_err_pulse.sv
module cec_err_pulse
  import cec_err_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned PULSE_US    = 3600,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_en_i,
  input  logic err_pulse_en_i,
  input  logic wait_rise_i,
  input  logic rx_busy_i,
  input  logic bit_err_i,
  input  logic bus_i,
  input  logic edge_clr_i,
  output logic pull_low_o,
  output logic busy_o,
  output logic edge_flag_o
);
  localparam int unsigned TICKS = pulse_ticks(CLK_HZ, PULSE_US);

  pulse_state_e state_q, state_d;
  logic en_q, en_rise, both_en, trigger;
  logic bus_rise, tmr_done, tmr_load, pull_q;

  cec_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_i      (bus_i),
    .clr_i      (edge_clr_i),
    .rise_o     (bus_rise),
    .edge_flag_o(edge_flag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= err_pulse_en_i;
  end

  assign en_rise = err_pulse_en_i & ~en_q;
  assign both_en = rx_en_i & err_pulse_en_i;
  assign trigger = both_en & (bit_err_i | (en_rise & ~rx_busy_i));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (trigger) state_d = wait_rise_i ? ST_WAIT : ST_DRIVE;
      ST_WAIT:  if (!both_en) state_d = ST_IDLE;
                else if (bus_rise) state_d = ST_DRIVE;
      ST_DRIVE: if (tmr_done) state_d = ST_TAIL;
      ST_TAIL:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = (state_q != ST_DRIVE) && (state_d == ST_DRIVE);

  cec_pulse_timer #(.TICKS(TICKS)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .run_i (state_q == ST_DRIVE),
    .done_o(tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pull_q  <= (state_d == ST_DRIVE);
    end
  end

  assign pull_low_o = pull_q;
  assign busy_o     = (state_q != ST_IDLE);

  AST_START_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_low_o) |-> $past(rx_en_i) && $past(err_pulse_en_i));  // R3
  AST_DRIVE_IS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_low_o |-> busy_o);  // R10
  AST_TAIL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_low_o) |-> busy_o);  // R10
  AST_WAIT_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_low_o) && $past(state_q == ST_WAIT) |-> $past(bus_rise));  // R6
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DRIVE && !tmr_done |=> pull_low_o);  // R8
endmodule

// File: tb/cec_err_pulse_bench.sv
module cec_err_pulse_bench;
  localparam int unsigned CLK_HZ = 10_000;
  localparam int unsigned TICKS  = ((CLK_HZ / 1000) * 3600) / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 0, pen = 0, wait_rise = 0, rx_busy = 0, bit_err = 0, bus = 1, clr = 0;
  logic pull_low, busy, flag;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  cec_err_pulse #(.CLK_HZ(CLK_HZ)) u_cec_err_pulse (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .err_pulse_en_i(pen),
    .wait_rise_i(wait_rise), .rx_busy_i(rx_busy), .bit_err_i(bit_err),
    .bus_i(bus), .edge_clr_i(clr), .pull_low_o(pull_low), .busy_o(busy),
    .edge_flag_o(flag)
  );

  function automatic bit want_err(int unsigned r);
    return (r % 3) == 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    bit_err = 1; tick(1); bit_err = 0;
  endtask

  // entered at the first negedge with pull_low high
  task automatic run_pulse(string req, bit noisy);
    int n = 0;
    while (pull_low && n < 4 * TICKS) begin
      n++;
      bit_err = noisy ? want_err($urandom) : 1'b0;
      tick(1);
    end
    bit_err = 0;
    check(n == TICKS, req, n, TICKS);
    check(busy == 1'b1, "R10 tail busy", busy, 1);
    tick(1);
    check(busy == 1'b0, "R10 idle after tail", busy, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    bit seen;
    void'($urandom(32'd1234));
    tick(2); rst_n = 1; tick(1);
    check(!pull_low && !busy && !flag, "R1 reset", {pull_low, busy, flag}, 0);

    // R3: pulse enable low
    rx_en = 1; seen = 0;
    for (int i = 0; i < 20; i++) begin
      bit_err = want_err($urandom); tick(1); seen |= pull_low | busy;
    end
    bit_err = 0; tick(2); seen |= pull_low;
    check(!seen, "R3 no pulse when disabled", seen, 0);

    // R11: receive disabled
    rx_en = 0; pen = 1; tick(1); seen = 0;
    for (int i = 0; i < 10; i++) begin strobe(); seen |= pull_low | busy; end
    check(!seen, "R11 no pulse with rx off", seen, 0);

    // R4/R2: immediate pulse
    rx_en = 1; tick(2);
    check(!pull_low, "R4 no spurious pulse", pull_low, 0);
    strobe();
    check(pull_low && busy, "R4 pulse starts", {pull_low, busy}, 3);
    run_pulse("R2 pulse length", 1'b0);

    // R7: strobes during pulse ignored
    strobe();
    run_pulse("R7 length with strobes", 1'b1);

    // R5: software start
    pen = 0; tick(2); pen = 1; tick(1);
    check(pull_low, "R5 software start", pull_low, 1);
    run_pulse("R5 sw pulse length", 1'b0);
    pen = 0; rx_busy = 1; tick(1); pen = 1; tick(3);
    check(!pull_low && !busy, "R5 blocked while receiving", {pull_low, busy}, 0);
    rx_busy = 0;

    // R6: wait for rising edge
    wait_rise = 1; bus = 0; tick(4);
    strobe(); tick(5);
    check(!pull_low && busy, "R6 pending", {pull_low, busy}, 1);
    bus = 1; tick(2);
    check(!pull_low, "R6 not before sync", pull_low, 0);
    tick(1);
    check(pull_low, "R6 starts on rise", pull_low, 1);
    run_pulse("R6 pulse length", 1'b0);

    // R8: cancel while waiting
    bus = 0; tick(4); strobe(); tick(1);
    rx_en = 0; tick(1); rx_en = 1;
    check(!busy, "R8 cancelled", busy, 0);
    bus = 1; tick(4);
    check(!pull_low, "R8 no pulse after cancel", pull_low, 0);

    // R8: drive runs to end despite disable
    wait_rise = 0; strobe();
    pen = 0;
    run_pulse("R8 full length after disable", 1'b0);
    rx_busy = 1; pen = 1; tick(1); rx_busy = 0; tick(1);

    // R9: edge flag
    clr = 1; tick(1); clr = 0;
    check(!flag, "R9 cleared", flag, 0);
    bus = 0; tick(2);
    check(!flag, "R9 not yet set", flag, 0);
    tick(1);
    check(flag, "R9 set on change", flag, 1);
    tick(5);
    check(flag, "R9 sticky", flag, 1);
    clr = 1; tick(1); clr = 0;
    check(!flag, "R9 clear", flag, 0);
    bus = 1; tick(2); clr = 1; tick(1); clr = 0;
    check(flag, "R9 set wins over clear", flag, 1);

    // random mix of modes (R4, R6)
    for (int it = 0; it < 6; it++) begin
      int d;
      wait_rise = $urandom % 2;
      d = 1 + ($urandom % 8);
      bus = 0; tick(4);
      strobe();
      if (wait_rise) begin
        tick(d);
        check(!pull_low && busy, "R6 random pending", {pull_low, busy}, 1);
        bus = 1; tick(3);
        check(pull_low, "R6 random start", pull_low, 1);
      end else begin
        check(pull_low, "R4 random start", pull_low, 1);
      end
      run_pulse("R2 random length", 1'b1);
      bus = 1; tick(d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule